// File: doc/BRIEF.md
# Zero-Padded Windowed SAD Engine

This block measures how far apart two square pixel windows are. The measure is the sum of absolute differences between pixels at the same row and column. The native window is 11x11 pixels of 8 bits each. Each operand arrives row-serially, one full row of 11 pixels per clock. The first row is marked with a start strobe, and the remaining ten rows follow on the next ten clocks without gaps. The cost appears on its own output with a one-cycle valid flag.

A mode input, sampled with the start strobe, selects between two uses. Full mode compares the whole 11x11 window. Block mode compares 8x8 blocks placed in rows 0..7 and columns 0..7 of the same window. The engine itself forces rows 8..10 and columns 8..10 to zero on both operands, whatever the inputs carry there. Both modes take exactly the same number of cycles, so one datapath serves both without a second processing element. Fetching pixels from memory and picking the best of several costs are left to the surrounding logic.

Top module: `zp_sad_engine`

## Requirements
- R1: In full mode (mode_i = 0 at start) cost_o equals the sum of |a - b| over all 121 positions. Pixel column c of a row sits in bits [8c+7:8c] of row_a_i and row_b_i, and row r is the r-th row after start, with row 0 presented with start.
- R2: In block mode (mode_i = 1 at start) positions with row >= 8 or column >= 8 contribute exactly zero, whatever the inputs carry there. The cost is the sum of |a - b| over the 8x8 area only.
- R3: The 15-bit cost holds the largest possible sum without wrap: 30855 in full mode and 16320 in block mode.
- R4: If start is sampled at clock edge k, cost_valid_o is 1 for exactly the cycle between edges k+11 and k+12, in both modes.
- R5: A start clears the accumulation. A new start in the cycle right after the previous 11th row gives two independent, correct costs.
- R6: A start sampled while a comparison is still taking rows abandons that comparison. No cost is produced for it, and the new one proceeds normally.
- R7: mode_i is used only in the cycle of start. Changes during the following ten rows do not alter the result.
- R8: While reset is asserted, and after its release until the first result, cost_valid_o is 0 and cost_o is 0.
- R9: Row inputs presented while no comparison is active do not change cost_o and do not raise cost_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = full 11x11 window, 1 = 8x8 block with zero padding; sampled with start_i |
| start_i | input | 1 | Marks row 0 of a new comparison |
| row_a_i | input | 88 | One row of operand A, 11 pixels of 8 bits, column 0 in the low byte |
| row_b_i | input | 88 | One row of operand B, same layout |
| cost_o | output | 15 | Sum of absolute differences of the last finished comparison |
| cost_valid_o | output | 1 | One-cycle flag that cost_o carries a new result |

## Verification
The hardest situations to reach from the ports are those where the padding or the restart logic can go wrong unseen. Two block-mode operands may differ only in padded rows and columns, and the expected cost is then zero. A comparison may be cut short by a new start, or followed at once by another one. The stimulus drives operands that are equal inside the 8x8 area and different everywhere outside it. It flips mode_i during the ten rows after each start. It issues starts after six rows and back-to-back with no idle cycle. Expected costs and their exact arrival cycles are queued by the driver and matched by a monitor on every edge.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_PAD  = 1'b1
  } sad_mode_e;
endpackage

// File: rtl/sad_rst_sync.sv
module sad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sad_row_ctrl.sv
module sad_row_ctrl
  import sad_pkg::*;
#(
  parameter int WIN = 11,
  localparam int IDX_W = $clog2(WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  output logic             act_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             pad_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  sad_mode_e        mode_q, mode_d;

  // Row currently presented at the ports
  always_comb begin
    act_o   = start_i | busy_q;
    idx_o   = start_i ? '0 : cnt_q;
    pad_o   = start_i ? mode_i : (mode_q == MODE_PAD);
    first_o = start_i;
    last_o  = act_o && (idx_o == LAST_IDX);
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = IDX_W'(1);
      mode_d = sad_mode_e'(mode_i);
    end else if (busy_q) begin
      if (cnt_q == LAST_IDX) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_FULL;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (start_i) mode_q <= mode_d;
    end
  end

  // R4: row counter never leaves the window while busy
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q >= IDX_W'(1)) && (cnt_q <= LAST_IDX));
  // R7: mode held for the whole comparison once taken
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start_i) |=> $stable(mode_q));
endmodule

// File: rtl/sad_row_diff.sv
module sad_row_diff #(
  parameter int WIN   = 11,
  parameter int BLK   = 8,
  parameter int PIX_W = 8,
  localparam int IDX_W = $clog2(WIN),
  localparam int ROW_W = PIX_W + $clog2(WIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIN*PIX_W-1:0] row_a_i,
  input  logic [WIN*PIX_W-1:0] row_b_i,
  input  logic                 act_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 pad_i,
  input  logic                 first_i,
  input  logic                 last_i,
  output logic [ROW_W-1:0]     rs_o,
  output logic                 rs_vld_o,
  output logic                 rs_first_o,
  output logic                 rs_last_o
);
  localparam int MAX_ROW = WIN * ((1 << PIX_W) - 1);

  logic             row_keep;
  logic [PIX_W-1:0] diff [WIN];
  logic [ROW_W-1:0] row_sum;

  assign row_keep = !pad_i || (int'(idx_i) < BLK);

  for (genvar c = 0; c < WIN; c++) begin : g_col
    logic             keep;
    logic [PIX_W-1:0] a_m, b_m;
    // Padding zeros forced on both operands inside the engine
    assign keep = row_keep && (!pad_i || (c < BLK));
    assign a_m  = keep ? row_a_i[c*PIX_W +: PIX_W] : '0;
    assign b_m  = keep ? row_b_i[c*PIX_W +: PIX_W] : '0;
    assign diff[c] = (a_m > b_m) ? (a_m - b_m) : (b_m - a_m);
  end

  always_comb begin
    row_sum = '0;
    for (int c = 0; c < WIN; c++) row_sum = row_sum + ROW_W'(diff[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_o       <= '0;
      rs_vld_o   <= 1'b0;
      rs_first_o <= 1'b0;
      rs_last_o  <= 1'b0;
    end else begin
      rs_vld_o <= act_i;
      if (act_i) begin
        rs_o       <= row_sum;
        rs_first_o <= first_i;
        rs_last_o  <= last_i;
      end
    end
  end

  // R2: padded rows yield a zero row sum
  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && pad_i && (int'(idx_i) >= BLK)) |=> (rs_o == '0));
  // R3: a row sum never exceeds its bound
  p_row_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rs_vld_o |-> (int'(rs_o) <= MAX_ROW));
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int WIN   = 11,
  parameter int PIX_W = 8,
  localparam int ROW_W  = PIX_W + $clog2(WIN),
  localparam int COST_W = PIX_W + $clog2(WIN*WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  rs_i,
  input  logic              vld_i,
  input  logic              first_i,
  input  logic              last_i,
  output logic [COST_W-1:0] cost_o,
  output logic              cost_valid_o
);
  localparam int MAX_COST = WIN * WIN * ((1 << PIX_W) - 1);

  logic [COST_W-1:0] acc_q, acc_d;
  logic [COST_W-1:0] base;
  logic [COST_W:0]   wide_sum;
  logic [COST_W-1:0] cost_q, cost_d;
  logic              valid_q, valid_d;

  always_comb begin
    base     = first_i ? '0 : acc_q;
    wide_sum = {1'b0, base} + (COST_W+1)'(rs_i);
    acc_d    = acc_q;
    cost_d   = cost_q;
    valid_d  = 1'b0;
    if (vld_i) begin
      acc_d = wide_sum[COST_W-1:0];
      if (last_i) begin
        cost_d  = wide_sum[COST_W-1:0];
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cost_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (vld_i) acc_q <= acc_d;
      if (vld_i && last_i) cost_q <= cost_d;
    end
  end

  assign cost_o       = cost_q;
  assign cost_valid_o = valid_q;

  // R4: result flag lasts a single cycle
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R3: accumulation never exceeds the cost width
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (int'(wide_sum) <= MAX_COST));
  // R5: first row restarts the running sum
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && first_i) |=> (acc_q == COST_W'($past(rs_i))));
  // R9: outputs move only when a last row is taken
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_i && last_i) |=> ($stable(cost_q) && !valid_q));
endmodule

// File: rtl/zp_sad_engine.sv
module zp_sad_engine #(
  parameter int WIN   = 11,
  parameter int BLK   = 8,
  parameter int PIX_W = 8,
  localparam int COST_W = PIX_W + $clog2(WIN*WIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_i,
  input  logic                 start_i,
  input  logic [WIN*PIX_W-1:0] row_a_i,
  input  logic [WIN*PIX_W-1:0] row_b_i,
  output logic [COST_W-1:0]    cost_o,
  output logic                 cost_valid_o
);
  localparam int IDX_W = $clog2(WIN);
  localparam int ROW_W = PIX_W + $clog2(WIN);

  logic             rst_sync_n;
  logic             act, pad, first, last;
  logic [IDX_W-1:0] idx;
  logic [ROW_W-1:0] rs;
  logic             rs_vld, rs_first, rs_last;

  sad_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sad_row_ctrl #(.WIN(WIN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .act_o   (act),
    .idx_o   (idx),
    .pad_o   (pad),
    .first_o (first),
    .last_o  (last)
  );

  sad_row_diff #(.WIN(WIN), .BLK(BLK), .PIX_W(PIX_W)) u_diff (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .row_a_i    (row_a_i),
    .row_b_i    (row_b_i),
    .act_i      (act),
    .idx_i      (idx),
    .pad_i      (pad),
    .first_i    (first),
    .last_i     (last),
    .rs_o       (rs),
    .rs_vld_o   (rs_vld),
    .rs_first_o (rs_first),
    .rs_last_o  (rs_last)
  );

  sad_accum #(.WIN(WIN), .PIX_W(PIX_W)) u_acc (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rs_i         (rs),
    .vld_i        (rs_vld),
    .first_i      (rs_first),
    .last_i       (rs_last),
    .cost_o       (cost_o),
    .cost_valid_o (cost_valid_o)
  );

  // R4: a result follows the last row after one pipeline stage
  p_valid_after_last_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rs_vld && rs_last) |=> cost_valid_o);
  // R8: no result while the synchronised reset is held
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_sync_n |-> (!cost_valid_o && (cost_o == '0)));
endmodule

// File: tb/zp_sad_engine_bench.sv
module zp_sad_engine_bench;
  localparam int WIN = 11;
  localparam int BLK = 8;
  localparam int PW  = 8;
  localparam int CW  = 15;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              mode_i, start_i;
  logic [WIN*PW-1:0] row_a_i, row_b_i;
  logic [CW-1:0]     cost_o;
  logic              cost_valid_o;

  always #4 clk = ~clk;

  zp_sad_engine u_zp_sad_engine (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .start_i (start_i),
    .row_a_i (row_a_i), .row_b_i (row_b_i),
    .cost_o (cost_o), .cost_valid_o (cost_valid_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  int    exp_val [64];
  int    exp_cyc [64];
  string exp_tag [64];
  int    wr = 0;
  int    rd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind 0 hash, 1 constant, 2 ramp, 3 equal inside 8x8 and different outside
  function automatic logic [7:0] pix(int kind, int seed, int r, int c, bit isb);
    case (kind)
      0: return 8'(seed * 37 + r * 101 + c * 59 + r * c * 13 + (isb ? 71 : 0));
      1: return 8'(seed);
      2: return 8'(seed + r * 11 + c);
      default: return (isb && (r >= BLK || c >= BLK)) ? ~8'(seed) : 8'(seed);
    endcase
  endfunction

  function automatic int exp_cost(bit md, int kind, int sa, int sb);
    int s = 0;
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++) begin
        int a, b;
        if (md && (r >= BLK || c >= BLK)) continue;
        a = int'(pix(kind, sa, r, c, 1'b0));
        b = int'(pix(kind, (kind == 3) ? sa : sb, r, c, 1'b1));
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  // Monitor: every result is matched to the queued value and cycle (R4)
  always @(negedge clk) begin
    if (mon_on) begin
      if (cost_valid_o) begin
        if (rd == wr) chk(1'b0, "R4 unexpected valid", 1, 0);
        else begin
          chk(cyc == exp_cyc[rd], "R4 result cycle", cyc, exp_cyc[rd]);
          chk(int'(cost_o) == exp_val[rd], exp_tag[rd], int'(cost_o), exp_val[rd]);
          rd++;
        end
      end else if (rd < wr && exp_cyc[rd] <= cyc) begin
        chk(1'b0, "R4 missing result", cyc, exp_cyc[rd]);
        rd++;
      end
    end
  end

  task automatic drive_rows(input bit md, input int kind, input int sa, input int sb,
                            input bit flip, input int nrows, input string tag);
    for (int r = 0; r < nrows; r++) begin
      @(negedge clk);
      start_i = (r == 0);
      mode_i  = (r == 0) ? md : (flip ? ~md : md);
      for (int c = 0; c < WIN; c++) begin
        row_a_i[c*PW +: PW] = pix(kind, sa, r, c, 1'b0);
        row_b_i[c*PW +: PW] = pix(kind, (kind == 3) ? sa : sb, r, c, 1'b1);
      end
      if (r == 0 && nrows == WIN) begin
        exp_val[wr] = exp_cost(md, kind, sa, sb);
        exp_cyc[wr] = cyc + 12;
        exp_tag[wr] = tag;
        wr++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      mode_i  = i[0];
      for (int c = 0; c < WIN; c++) begin
        row_a_i[c*PW +: PW] = 8'(i * 53 + c * 29 + 7);
        row_b_i[c*PW +: PW] = 8'(i * 17 + c * 91);
      end
    end
  endtask

  // {mode, kind[1:0], seed_a[7:0], seed_b[7:0]}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 2'd1, 8'd255, 8'd0},
    {1'b0, 2'd0, 8'd3,   8'd200},
    {1'b0, 2'd2, 8'd10,  8'd90},
    {1'b1, 2'd0, 8'd77,  8'd5},
    {1'b1, 2'd1, 8'd255, 8'd0},
    {1'b1, 2'd2, 8'd250, 8'd3},
    {1'b0, 2'd3, 8'd50,  8'd0},
    {1'b1, 2'd3, 8'd50,  8'd0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] held;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; row_a_i = '0; row_b_i = '0;
    repeat (3) @(negedge clk);
    chk(cost_valid_o == 1'b0, "R8 valid in reset", int'(cost_valid_o), 0);
    chk(cost_o == '0, "R8 cost in reset", int'(cost_o), 0);
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    idle(4);
    chk(cost_valid_o == 1'b0, "R8 valid after release", int'(cost_valid_o), 0);
    chk(cost_o == '0, "R8 cost after release", int'(cost_o), 0);

    // Table walk: R1 full, R2 block mode, R3 maximum sums
    for (int v = 0; v < 8; v++) begin
      drive_rows(VEC[v][18], int'(VEC[v][17:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]),
                 1'b0, WIN, VEC[v][18] ? "R2 block cost" : "R1 full cost");
      idle(3);
    end
    chk(exp_cost(1'b0, 1, 255, 0) == 30855, "R3 full max", exp_cost(1'b0, 1, 255, 0), 30855);
    chk(exp_cost(1'b1, 1, 255, 0) == 16320, "R3 block max", exp_cost(1'b1, 1, 255, 0), 16320);
    chk(exp_cost(1'b1, 3, 50, 0) == 0, "R2 padding only differs", exp_cost(1'b1, 3, 50, 0), 0);

    // R9: idle rows leave the held cost untouched
    held = cost_o;
    idle(6);
    chk(cost_o == held, "R9 cost held over idle rows", int'(cost_o), int'(held));
    chk(cost_valid_o == 1'b0, "R9 no valid over idle rows", int'(cost_valid_o), 0);

    // R5: back-to-back comparisons with no gap, mixed modes
    drive_rows(1'b0, 1, 255, 0, 1'b0, WIN, "R5 back-to-back first");
    drive_rows(1'b1, 0, 9, 140, 1'b0, WIN, "R5 back-to-back second");
    drive_rows(1'b0, 2, 4, 0, 1'b0, WIN, "R5 back-to-back third");
    idle(3);

    // R6: abort after six rows, then a full comparison
    drive_rows(1'b0, 1, 255, 0, 1'b0, 6, "R6 aborted");
    drive_rows(1'b1, 2, 30, 200, 1'b0, WIN, "R6 after abort");
    idle(2);
    drive_rows(1'b1, 3, 99, 0, 1'b0, 10, "R6 aborted at row 9");
    drive_rows(1'b0, 0, 1, 2, 1'b0, WIN, "R6 after late abort");
    idle(3);

    // R7: mode flips during the rows after start
    drive_rows(1'b1, 3, 120, 0, 1'b1, WIN, "R7 block with mode flips");
    drive_rows(1'b0, 3, 120, 0, 1'b1, WIN, "R7 full with mode flips");
    idle(16);
    chk(rd == wr, "R4 all results delivered", rd, wr);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule